// File: doc/BRIEF.md
# Atomic Set/Clear GPIO Controller

This block controls 32 general-purpose I/O lanes from a small register bus. Every per-lane control register is changed through one atomic write word. Ones in the lower half of the word turn lane bits on, and ones in the upper half turn them off. Software can therefore change a single lane without reading the register first. The lanes are split into two banks of sixteen. The low bank is decoded at byte offset 0x00 and the high bank at byte offset 0x80, and both banks use the same register layout.

Pad inputs pass through a two-flop synchronizer. The synchronized level is used for the gated level read-back and for the sticky rising-edge and falling-edge flags, which software clears by writing ones. Each lane also has a 4-bit event-map field that holds an event pair number and a power-management marker. Pad output enables are derived from the output-enable bit and the two output-auxiliary selects.

The block has no state machine. Its behaviour is register updates at bus writes, registered read data, and combinational pad drive.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: Register offsets within a bank are word addresses (bus_addr[1:0] must be 00, otherwise the access is ignored and reads 0): 0x00 output value, 0x04 output enable, 0x08 input enable, 0x0C output-aux select A, 0x10 output-aux select B, 0x14 input-aux select, 0x18 level read-back (read-only), 0x1C rising flags, 0x20 falling flags, 0x24 event map of bank lanes 0–7, 0x28 event map of bank lanes 8–15. In the six control registers (0x00–0x14), write bit n (n = 0..15) sets lane n of the bank and bit n+16 clears it. Lanes with zero in both halves keep their value.
- R2: If one write both sets and clears the same lane, the lane ends up cleared.
- R3: bus_addr[7]=1 selects the high bank, lanes 16–31. Lane k of the high bank sits at bit k−16.
- R4: A read returns the bank's per-lane state in bits 15:0 and zeros in bits 31:16. bus_rdata is loaded at the clock edge that samples bus_rd and holds until the next read.
- R5: The rising and falling flags of a lane latch edges of the synchronized pad level only while that lane's input enable is 1. The flags stay set until cleared.
- R6: Writing a 1 to bit n of a flag register clears lane n's flag, and the upper 16 write bits are ignored. An edge that arrives in the same cycle as the clear wins, so the flag stays set.
- R7: The event-map field of lane L sits at bits (L mod 8)*4+3 .. (L mod 8)*4. Bits 2:0 of the field hold the event pair number and bit 3 the power-management marker. Fields are written as a plain 32-bit word.
- R8: Lanes 23, 29, 30 and 31 are reserved. Writes to their control bits, flags and event-map fields are ignored, their reads return 0, and their pad_oe is 0.
- R9: pad_oe of a lane is 1 only when output enable is 1 and both output-aux selects are 0. pad_out equals the output value where pad_oe is 1 and is 0 elsewhere.
- R10: Level read-back returns the synchronized pad level for lanes whose input enable is 1, and 0 for the other lanes. Writes to the level register have no effect.
- R11: After reset, every control bit, edge flag, event-map field and bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |

## Verification
A control-register write takes effect at the edge that samples bus_wr, so pad_oe and pad_out are checked at the following falling edge. Read data is due at the edge that samples bus_rd, and the bench reads it at the next falling edge after dropping the strobe. A pad change reaches the level read-back two edges later and the edge flags three edges later. The bench therefore waits six cycles after toggling pads before it reads level or flags. During the random phase the pads are held constant, so no edge can arise while the reference model is being compared.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

    typedef enum logic [4:0] {
        RS_OVAL   = 5'd0,
        RS_OEN    = 5'd1,
        RS_IEN    = 5'd2,
        RS_OAUXA  = 5'd3,
        RS_OAUXB  = 5'd4,
        RS_IAUX   = 5'd5,
        RS_LEVEL  = 5'd6,
        RS_RISE   = 5'd7,
        RS_FALL   = 5'd8,
        RS_EVMAP0 = 5'd9,
        RS_EVMAP1 = 5'd10
    } reg_sel_e;

    // atomic update: low half sets, high half clears, clear dominates
    function automatic logic [15:0] setclr16(input logic [15:0] cur,
                                             input logic [31:0] wd,
                                             input logic [15:0] keep);
        return ((cur | wd[15:0]) & ~wd[31:16]) & keep;
    endfunction

endpackage

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_sc_bank.sv
module gpio_sc_bank
    import gpio_sc_pkg::*;
#(
    parameter int             BL   = 16,
    parameter logic [BL-1:0]  RSVD = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  reg_sel_e      reg_sel,
    input  logic [31:0]   wdata,
    input  logic [BL-1:0] pin_sync,
    output logic [BL-1:0] out_val,
    output logic [BL-1:0] out_en,
    output logic [BL-1:0] oaux_a,
    output logic [BL-1:0] oaux_b,
    output logic [31:0]   rd_word
);
    localparam int EV_REGS = BL / 8;

    logic [BL-1:0] in_en, iaux, rise_flags, fall_flags, prev_q;
    logic [BL-1:0] rise_now, fall_now, keep;
    logic [31:0]   evmap_q [EV_REGS];
    logic [31:0]   ev_keep [EV_REGS];

    assign keep     = ~RSVD;
    assign rise_now = pin_sync & ~prev_q & in_en;
    assign fall_now = ~pin_sync & prev_q & in_en;

    // nibble masks that drop reserved lanes from the event map
    always_comb begin
        for (int e = 0; e < EV_REGS; e++) begin
            for (int n = 0; n < 8; n++) begin
                ev_keep[e][n*4 +: 4] = {4{keep[e*8 + n]}};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_val    <= '0;
            out_en     <= '0;
            in_en      <= '0;
            oaux_a     <= '0;
            oaux_b     <= '0;
            iaux       <= '0;
            rise_flags <= '0;
            fall_flags <= '0;
            prev_q     <= '0;
        end else begin
            prev_q     <= pin_sync;
            rise_flags <= ((wr_en && reg_sel == RS_RISE) ?
                           (rise_flags & ~wdata[BL-1:0]) : rise_flags) | (rise_now & keep);
            fall_flags <= ((wr_en && reg_sel == RS_FALL) ?
                           (fall_flags & ~wdata[BL-1:0]) : fall_flags) | (fall_now & keep);
            if (wr_en) begin
                unique case (reg_sel)
                    RS_OVAL:  out_val <= setclr16(out_val, wdata, keep);
                    RS_OEN:   out_en  <= setclr16(out_en,  wdata, keep);
                    RS_IEN:   in_en   <= setclr16(in_en,   wdata, keep);
                    RS_OAUXA: oaux_a  <= setclr16(oaux_a,  wdata, keep);
                    RS_OAUXB: oaux_b  <= setclr16(oaux_b,  wdata, keep);
                    RS_IAUX:  iaux    <= setclr16(iaux,    wdata, keep);
                    default:  ;
                endcase
            end
        end
    end

    generate
        for (genvar e = 0; e < EV_REGS; e++) begin : g_ev
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    evmap_q[e] <= '0;
                else if (wr_en && reg_sel == reg_sel_e'(int'(RS_EVMAP0) + e))
                    evmap_q[e] <= wdata & ev_keep[e];
            end
        end
    endgenerate

    always_comb begin
        rd_word = '0;
        unique case (reg_sel)
            RS_OVAL:   rd_word[BL-1:0] = out_val;
            RS_OEN:    rd_word[BL-1:0] = out_en;
            RS_IEN:    rd_word[BL-1:0] = in_en;
            RS_OAUXA:  rd_word[BL-1:0] = oaux_a;
            RS_OAUXB:  rd_word[BL-1:0] = oaux_b;
            RS_IAUX:   rd_word[BL-1:0] = iaux;
            RS_LEVEL:  rd_word[BL-1:0] = pin_sync & in_en;
            RS_RISE:   rd_word[BL-1:0] = rise_flags;
            RS_FALL:   rd_word[BL-1:0] = fall_flags;
            RS_EVMAP0: rd_word         = evmap_q[0];
            RS_EVMAP1: rd_word         = evmap_q[EV_REGS-1];
            default:   rd_word         = '0;
        endcase
    end

    // R1: lanes untouched by a non-output-value access keep their state
    a_r1_hold_oval: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_sel == RS_OVAL) |=> $stable(out_val));

    // R2: a lane named in the clear half is zero after the write
    a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == RS_OVAL) |=> ((out_val & $past(wdata[BL+15:16])) == '0));

    // R5: lanes with input disabled never gain a rising flag
    a_r5_gate_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_sel == RS_RISE) |=>
            ((rise_flags & ~$past(in_en)) == ($past(rise_flags) & ~$past(in_en))));

    // R6: written-one lanes are clear unless a fresh edge arrived
    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == RS_FALL) |=>
            ((fall_flags & $past(wdata[BL-1:0]) & ~$past(fall_now)) == '0));

    // R8: reserved lanes never hold flags
    a_r8_rsvd_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_flags | fall_flags) & RSVD) == '0);
endmodule

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl
    import gpio_sc_pkg::*;
#(
    parameter int          LANES     = 32,
    parameter int          ADDR_W    = 8,
    parameter logic [31:0] RSVD_MASK = 32'hE080_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic [LANES-1:0]  pad_in,
    output logic [LANES-1:0]  pad_out,
    output logic [LANES-1:0]  pad_oe
);
    localparam int BL    = LANES / 2;
    localparam int NBANK = 2;

    logic [LANES-1:0] pin_sync;
    logic [LANES-1:0] oval, oen, oxa, oxb;
    logic [31:0]      bank_rd [NBANK];
    logic             aligned, bank_hi;
    reg_sel_e         sel;

    assign aligned = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-2:2] <= 5'd10);
    assign bank_hi = bus_addr[ADDR_W-1];
    assign sel     = reg_sel_e'(bus_addr[6:2]);

    gpio_sc_sync #(.W(LANES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_async(pad_in), .q_sync(pin_sync)
    );

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            gpio_sc_bank #(.BL(BL), .RSVD(RSVD_MASK[b*BL +: BL])) bank_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (bus_wr && aligned && (bank_hi == b[0])),
                .reg_sel (sel),
                .wdata   (bus_wdata),
                .pin_sync(pin_sync[b*BL +: BL]),
                .out_val (oval[b*BL +: BL]),
                .out_en  (oen[b*BL +: BL]),
                .oaux_a  (oxa[b*BL +: BL]),
                .oaux_b  (oxb[b*BL +: BL]),
                .rd_word (bank_rd[b])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= aligned ? bank_rd[bank_hi] : '0;
    end

    assign pad_oe  = oen & ~oxa & ~oxb & ~RSVD_MASK[LANES-1:0];
    assign pad_out = oval & pad_oe;

    // R9: nothing is driven high where the output is disabled
    always_comb begin
        a_r9_out_gated: assert ((pad_out & ~pad_oe) == '0);
    end

    // R8: reserved lanes are never enabled as outputs
    a_r8_rsvd_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & RSVD_MASK[LANES-1:0]) == '0);

    // R4: upper half of a control-register read is always zero
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel <= RS_FALL) |=> (bus_rdata[31:16] == 16'h0));
endmodule

// File: tb/gpio_setclr_ctrl_tb_top.sv
module gpio_setclr_ctrl_tb_top;
    localparam int          CLK_P = 10;
    localparam logic [31:0] RSVD  = 32'hE080_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pad_in = '0, pad_out, pad_oe;

    int n_chk = 0, n_fail = 0;

    // reference model, indexed by register 0..5
    logic [31:0] m_ctl [6];

    always #(CLK_P/2) clk = ~clk;

    gpio_setclr_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_setclr(input logic [31:0] cur, input bit hi,
                                               input logic [31:0] d);
        logic [15:0] c, keep;
        c    = hi ? cur[31:16] : cur[15:0];
        keep = hi ? ~RSVD[31:16] : ~RSVD[15:0];
        c    = (c | d[15:0]) & ~d[31:16] & keep;
        return hi ? {c, cur[15:0]} : {cur[31:16], c};
    endfunction

    function automatic logic [31:0] exp_oe();
        return m_ctl[1] & ~m_ctl[3] & ~m_ctl[4] & ~RSVD;
    endfunction

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7321));
        for (int i = 0; i < 6; i++) m_ctl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        check("R11 rdata", bus_rdata, 32'h0);
        check("R11 pad_oe", pad_oe, 32'h0);
        rd(8'h24, v); check("R11 evmap", v, 32'h0);
        rd(8'h9C, v); check("R11 rise hi", v, 32'h0);

        // R5/R10: edges and level gating (lane3, lane20 enabled; lane5 not)
        wr(8'h08, 32'h0000_0008); wr(8'h88, 32'h0000_0010);
        m_ctl[2] = 32'h0010_0008;
        pad_in = 32'h0010_0028;
        repeat (6) @(negedge clk);
        rd(8'h1C, v); check("R5 rise lo", v, 32'h0000_0008);
        rd(8'h9C, v); check("R5 rise hi lane20", v, 32'h0000_0010);
        rd(8'h20, v); check("R5 fall lo none", v, 32'h0);
        rd(8'h18, v); check("R10 level gated", v, 32'h0000_0008);
        rd(8'h98, v); check("R10 level hi", v, 32'h0000_0010);
        wr(8'h18, 32'h0000_FFFF);
        rd(8'h18, v); check("R10 level write ignored", v, 32'h0000_0008);
        // R6: high half ignored, then write-one clear
        wr(8'h1C, 32'hFFFF_0000);
        rd(8'h1C, v); check("R6 high half ignored", v, 32'h0000_0008);
        wr(8'h1C, 32'h0000_0008);
        rd(8'h1C, v); check("R6 w1c", v, 32'h0);
        pad_in = 32'h0010_0020;
        repeat (6) @(negedge clk);
        rd(8'h20, v); check("R5 fall lane3", v, 32'h0000_0008);
        rd(8'h1C, v); check("R5 sticky cleared stays", v, 32'h0);

        // R7/R8: event map layout and reserved fields
        wr(8'h28, 32'h9A3C_5E71);
        rd(8'h28, v); check("R7 evmap lanes 8-15", v, 32'h9A3C_5E71);
        check("R7 lane11 field", {28'h0, v[15:12]}, 32'h5);
        wr(8'hA4, 32'hFFFF_FFFF);
        rd(8'hA4, v); check("R8 lane23 field", v, 32'h0FFF_FFFF);
        wr(8'hA8, 32'hFFFF_FFFF);
        rd(8'hA8, v); check("R8 lanes29-31 fields", v, 32'h000F_FFFF);
        wr(8'h84, 32'h0000_FFFF); m_ctl[1] = exp_setclr(m_ctl[1], 1'b1, 32'h0000_FFFF);
        rd(8'h84, v); check("R8 reserved oe", v, 32'h0000_1F7F);
        check("R9 pad_oe hi", pad_oe, exp_oe());

        // R2: set and clear together
        wr(8'h00, 32'h0000_0001); wr(8'h00, 32'h0001_0001);
        rd(8'h00, v); check("R2 clear wins", v, 32'h0);

        // R1: misaligned access ignored
        wr(8'h01, 32'h0000_FFFF);
        rd(8'h00, v); check("R1 misaligned ignored", v, 32'h0);

        // random phase, pads held constant
        pad_in = 32'hA5C3_3C5A;
        repeat (6) @(negedge clk);
        for (int it = 0; it < 400; it++) begin
            int  r;
            bit  hi;
            logic [31:0] d;
            r  = $urandom_range(0, 6);
            hi = 1'($urandom_range(0, 1));
            d  = $urandom;
            if ($urandom_range(0, 3) == 0) d = d & 32'h0000_FFFF;
            wr({hi, r[4:0], 2'b00}, d);
            if (r < 6) m_ctl[r] = exp_setclr(m_ctl[r], hi, d);
            check("R9 pad_oe", pad_oe, exp_oe());
            check("R9 pad_out", pad_out, m_ctl[0] & exp_oe());
            r  = $urandom_range(0, 6);
            hi = 1'($urandom_range(0, 1));
            rd({hi, r[4:0], 2'b00}, v);
            if (r < 6)
                check(hi ? "R3 R1 R4 hi bank" : "R1 R4 lo bank", v,
                      hi ? {16'h0, m_ctl[r][31:16]} : {16'h0, m_ctl[r][15:0]});
            else
                check("R10 level", v,
                      hi ? {16'h0, (pad_in & m_ctl[2]) >> 16} : {16'h0, pad_in[15:0] & m_ctl[2][15:0]});
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule